// File: doc/BRIEF.md
# Iterative Multiply and Multiply-Add Unit

This block is the multiply engine of a 64-bit fixed-point execution unit. A pulse on `start` captures two operands, an optional third operand or a 16-bit immediate, and a 4-bit operation code. The unit builds the full 128-bit product over several cycles by shift-and-add, consuming `STEP` multiplier bits per cycle. It then adds the widened third operand if the operation asks for one and selects the half of the result that the operation wants. Word-size forms work on the low 32 bits of each operand.

When the result is ready, `done` pulses for one cycle. On that cycle the unit also presents an overflow flag with its write enable, for the forms that can overflow, and a four-bit condition field with its write enable when recording is requested. The enclosing pipeline owns register read and write, the summary-overflow state and issue control. It gives the current summary-overflow bit on `so_in`.

Top module: `fxu_mul_unit`

## Requirements
- R1: A `start` seen while the unit is idle is accepted at that clock edge. `busy` is high from the next cycle until `done` rises. `done` rises after the (64/STEP + 1)-th rising edge that follows the accepting edge (33 edges with the defaults) and stays high for exactly one cycle.
- R2: A `start` raised while `busy` is high is ignored. The pending result is still computed from the operands captured at acceptance, and no extra `done` pulse follows.
- R3: Op code 0 (low doubleword, signed) returns bits 63:0 of the signed 128-bit product. Its overflow condition holds when product bits 127:63 are neither all zero nor all one.
- R4: Op code 3 (low word, signed) multiplies bits 31:0 of each operand as signed values and returns the whole 64-bit product. Its overflow condition holds when product bits 63:31 are not all equal.
- R5: Op codes 1 (signed) and 2 (unsigned) return bits 127:64 of the 128-bit product of the two full operands.
- R6: Op codes 4 (signed) and 5 (unsigned) take bits 63:32 of the 64-bit product of the low operand words. They return that value in both result[63:32] and result[31:0].
- R7: Op code 6 sign-extends `imm` to 64 bits and returns bits 63:0 of its signed product with `src_a`.
- R8: Op codes 7 (high) and 9 (low) add the sign-extended `src_c` to the signed 128-bit product. They return bits 127:64 or bits 63:0 of the sum.
- R9: Op code 8 adds the zero-extended `src_c` to the unsigned 128-bit product and returns bits 127:64 of the sum.
- R10: `ov_wr` is high at `done` only when `oe` was set and the op code was 0 or 3. `ov` then carries that form's overflow condition. In all other cases `ov` is low.
- R11: `cr0_wr` is high at `done` only when `rec` was set and the op code was 0 to 5. `cr0` is {negative, positive, zero, so_in OR ov}, the first three taken from the 64-bit result as a signed number.
- R12: After reset, `busy`, `done`, `ov_wr`, `ov`, `cr0_wr`, `cr0` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation; taken only when idle |
| op | input | 4 | Operation code (0 to 9, see requirements) |
| oe | input | 1 | Request an overflow write for forms that support it |
| rec | input | 1 | Request a condition-field write for forms that support it |
| so_in | input | 1 | Current summary-overflow bit |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| src_c | input | 64 | Addend for multiply-add forms |
| imm | input | 16 | Signed immediate multiplier for op code 6 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result fields are valid |
| result | output | 64 | Selected 64-bit result |
| ov_wr | output | 1 | Write enable for the overflow flag |
| ov | output | 1 | Overflow flag |
| cr0_wr | output | 1 | Write enable for the condition field |
| cr0 | output | 4 | {negative, positive, zero, summary overflow} |

## Verification
All results, flags and enables come from registers loaded on the edge that raises `done`. With the default step of two bits, that is the 33rd rising edge after the accepting edge. The bench drives `start` on a falling edge and then counts falling edges. It requires `done` exactly at the 34th, where it compares every output against its model, and one falling edge later it requires `done` to have dropped. For the ignored-start case, the bench keeps watching for well past a second full latency and confirms that no further `done` pulse appears.

// File: rtl/fxu_mul_pkg.sv
package fxu_mul_pkg;

  typedef enum logic [3:0] {
    OP_MULLD   = 4'd0,
    OP_MULHD   = 4'd1,
    OP_MULHDU  = 4'd2,
    OP_MULLW   = 4'd3,
    OP_MULHW   = 4'd4,
    OP_MULHWU  = 4'd5,
    OP_MULI    = 4'd6,
    OP_MADDHD  = 4'd7,
    OP_MADDHDU = 4'd8,
    OP_MADDLD  = 4'd9
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_st_e;

  function automatic logic op_is_word(mul_op_e op);
    return (op == OP_MULLW) || (op == OP_MULHW) || (op == OP_MULHWU);
  endfunction

  function automatic logic op_is_unsigned(mul_op_e op);
    return (op == OP_MULHDU) || (op == OP_MULHWU) || (op == OP_MADDHDU);
  endfunction

  function automatic logic op_is_madd(mul_op_e op);
    return (op == OP_MADDHD) || (op == OP_MADDHDU) || (op == OP_MADDLD);
  endfunction

  function automatic logic op_can_ovf(mul_op_e op);
    return (op == OP_MULLD) || (op == OP_MULLW);
  endfunction

  function automatic logic op_can_rec(mul_op_e op);
    return (op == OP_MULLD) || (op == OP_MULHD) || (op == OP_MULHDU) ||
           (op == OP_MULLW) || (op == OP_MULHW) || (op == OP_MULHWU);
  endfunction

endpackage

// File: rtl/fxu_mul_prep.sv
module fxu_mul_prep
  import fxu_mul_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  mul_op_e             op,
  input  logic [XLEN-1:0]     src_a,
  input  logic [XLEN-1:0]     src_b,
  input  logic [XLEN-1:0]     src_c,
  input  logic [IMM_W-1:0]    imm,
  output logic [XLEN-1:0]     mag_a,
  output logic [XLEN-1:0]     mag_b,
  output logic                neg,
  output logic [2*XLEN-1:0]   addend
);
  localparam int unsigned HW = XLEN / 2;

  // Widen a half-width value, by sign or by zero.
  function automatic logic [XLEN-1:0] widen_half(logic [HW-1:0] x, logic sgn);
    return {{HW{sgn & x[HW-1]}}, x};
  endfunction

  // Absolute value when the operand is treated as signed.
  function automatic logic [XLEN-1:0] magnitude(logic [XLEN-1:0] x, logic sgn);
    return (sgn && x[XLEN-1]) ? (~x + 1'b1) : x;
  endfunction

  logic            is_uns;
  logic            is_word;
  logic [XLEN-1:0] ext_a;
  logic [XLEN-1:0] ext_b;

  always_comb begin
    is_uns  = op_is_unsigned(op);
    is_word = op_is_word(op);
    ext_a   = is_word ? widen_half(src_a[HW-1:0], !is_uns) : src_a;
    if (op == OP_MULI)
      ext_b = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    else if (is_word)
      ext_b = widen_half(src_b[HW-1:0], !is_uns);
    else
      ext_b = src_b;
    neg    = !is_uns && (ext_a[XLEN-1] ^ ext_b[XLEN-1]);
    mag_a  = magnitude(ext_a, !is_uns);
    mag_b  = magnitude(ext_b, !is_uns);
    addend = op_is_madd(op) ? {{XLEN{!is_uns & src_c[XLEN-1]}}, src_c} : '0;
  end

endmodule

// File: rtl/fxu_mul_core.sv
module fxu_mul_core #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step_en,
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  output logic [2*XLEN-1:0] prod
);
  localparam int unsigned PW = 2 * XLEN;

  logic [PW-1:0]   acc;
  logic [PW-1:0]   mcand;
  logic [XLEN-1:0] mplier;
  logic [PW-1:0]   acc_nxt;

  // Add the partial products for the STEP multiplier bits of this cycle.
  always_comb begin
    acc_nxt = acc;
    for (int j = 0; j < STEP; j++) begin
      if (mplier[j]) acc_nxt = acc_nxt + (mcand << j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= {{XLEN{1'b0}}, mag_a};
      mplier <= mag_b;
    end else if (step_en) begin
      acc    <= acc_nxt;
      mcand  <= mcand << STEP;
      mplier <= mplier >> STEP;
    end
  end

  assign prod = acc;

endmodule

// File: rtl/fxu_mul_select.sv
module fxu_mul_select
  import fxu_mul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  mul_op_e             op,
  input  logic [2*XLEN-1:0]   prod_mag,
  input  logic                neg,
  input  logic [2*XLEN-1:0]   addend,
  input  logic                oe,
  input  logic                rec,
  input  logic                so_in,
  output logic [XLEN-1:0]     res,
  output logic                ov_wr,
  output logic                ov,
  output logic                cr0_wr,
  output logic [3:0]          cr0
);
  localparam int unsigned HW = XLEN / 2;
  localparam int unsigned PW = 2 * XLEN;

  function automatic logic [PW-1:0] apply_sign(logic [PW-1:0] m, logic n);
    return n ? (~m + 1'b1) : m;
  endfunction

  // True when a field mixes zeros and ones.
  function automatic logic mixed_dw(logic [XLEN:0] x);
    return (|x) && !(&x);
  endfunction

  function automatic logic mixed_w(logic [HW:0] x);
    return (|x) && !(&x);
  endfunction

  logic [PW-1:0] full;
  logic          ovf;

  always_comb begin
    full = apply_sign(prod_mag, neg) + addend;
    unique case (op)
      OP_MULHD, OP_MULHDU, OP_MADDHD, OP_MADDHDU: res = full[PW-1:XLEN];
      OP_MULHW, OP_MULHWU: res = {full[XLEN-1:HW], full[XLEN-1:HW]};
      default: res = full[XLEN-1:0];
    endcase
    ovf    = (op == OP_MULLW) ? mixed_w(full[XLEN-1:HW-1]) : mixed_dw(full[PW-1:XLEN-1]);
    ov_wr  = oe && op_can_ovf(op);
    ov     = ov_wr && ovf;
    cr0_wr = rec && op_can_rec(op);
    cr0    = {res[XLEN-1], !res[XLEN-1] && (|res), ~|res, so_in | ov};
  end

endmodule

// File: rtl/fxu_mul_unit.sv
module fxu_mul_unit
  import fxu_mul_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned STEP  = 2,
  parameter int unsigned IMM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              oe,
  input  logic              rec,
  input  logic              so_in,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [XLEN-1:0]   src_c,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic              ov_wr,
  output logic              ov,
  output logic              cr0_wr,
  output logic [3:0]        cr0
);
  localparam int unsigned PW   = 2 * XLEN;
  localparam int unsigned ITER = XLEN / STEP;
  localparam int unsigned CW   = $clog2(ITER + 1);

  mul_st_e         state;
  logic [CW-1:0]   cnt;
  mul_op_e         op_q;
  logic            oe_q, rec_q, so_q, neg_q;
  logic [PW-1:0]   addend_q;

  // Named internal events
  logic accept, last_step, finish;
  assign accept    = start && (state == ST_IDLE);
  assign last_step = (state == ST_RUN) && (cnt == CW'(ITER - 1));
  assign finish    = (state == ST_FIN);

  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_w;
  logic [PW-1:0]   addend_w;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] res_w;
  logic            ov_wr_w, ov_w, cr0_wr_w;
  logic [3:0]      cr0_w;

  fxu_mul_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
    .op(mul_op_e'(op)), .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
    .mag_a(mag_a), .mag_b(mag_b), .neg(neg_w), .addend(addend_w)
  );

  fxu_mul_core #(.XLEN(XLEN), .STEP(STEP)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step_en(state == ST_RUN),
    .mag_a(mag_a), .mag_b(mag_b), .prod(prod)
  );

  fxu_mul_select #(.XLEN(XLEN)) u_sel (
    .op(op_q), .prod_mag(prod), .neg(neg_q), .addend(addend_q),
    .oe(oe_q), .rec(rec_q), .so_in(so_q),
    .res(res_w), .ov_wr(ov_wr_w), .ov(ov_w), .cr0_wr(cr0_wr_w), .cr0(cr0_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_q     <= OP_MULLD;
      oe_q     <= 1'b0;
      rec_q    <= 1'b0;
      so_q     <= 1'b0;
      neg_q    <= 1'b0;
      addend_q <= '0;
      done     <= 1'b0;
      result   <= '0;
      ov_wr    <= 1'b0;
      ov       <= 1'b0;
      cr0_wr   <= 1'b0;
      cr0      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          cnt      <= '0;
          op_q     <= mul_op_e'(op);
          oe_q     <= oe;
          rec_q    <= rec;
          so_q     <= so_in;
          neg_q    <= neg_w;
          addend_q <= addend_w;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= ST_FIN;
        end
        ST_FIN: begin
          state  <= ST_IDLE;
          done   <= 1'b1;
          result <= res_w;
          ov_wr  <= ov_wr_w;
          ov     <= ov_w;
          cr0_wr <= cr0_wr_w;
          cr0    <= cr0_w;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fxu_mul_unit_chk.sv
module fxu_mul_unit_chk
  import fxu_mul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            finish,
  input mul_op_e         op_q,
  input logic [XLEN-1:0] result,
  input logic            ov_wr,
  input logic            ov,
  input logic            cr0_wr,
  input logic [3:0]      cr0
);
  localparam int unsigned HW = XLEN / 2;

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r1_finish_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));

  a_r2_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  a_r6_word_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_MULHW || op_q == OP_MULHWU)) |-> (result[XLEN-1:HW] == result[HW-1:0]));

  a_r10_ov_forms: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ov_wr) |-> (op_q == OP_MULLD || op_q == OP_MULLW));

  a_r10_ov_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ov_wr) |-> !ov);

  a_r11_cr0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cr0_wr) |-> ($countones(cr0[3:1]) == 1));

  a_r11_rec_forms: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cr0_wr) |-> (op_q != OP_MULI && op_q != OP_MADDHD && op_q != OP_MADDHDU && op_q != OP_MADDLD));

endmodule

bind fxu_mul_unit fxu_mul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .finish(finish),
  .op_q(op_q), .result(result), .ov_wr(ov_wr), .ov(ov), .cr0_wr(cr0_wr), .cr0(cr0)
);

// File: tb/sim_fxu_mul_unit.sv
`timescale 1ns/1ps
module sim_fxu_mul_unit;
  localparam int STEP = 2;
  localparam int ITER = 64 / STEP;
  localparam int LAT  = ITER + 2;   // falling edges from start drive to done

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        oe = 1'b0, rec = 1'b0, so_in = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, src_c = '0;
  logic [15:0] imm = '0;
  logic        busy, done, ov_wr, ov, cr0_wr;
  logic [63:0] result;
  logic [3:0]  cr0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fxu_mul_unit #(.XLEN(64), .STEP(STEP), .IMM_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .oe(oe), .rec(rec), .so_in(so_in),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
    .busy(busy), .done(done), .result(result), .ov_wr(ov_wr), .ov(ov),
    .cr0_wr(cr0_wr), .cr0(cr0)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] sx(logic [63:0] x);
    return {{64{x[63]}}, x};
  endfunction

  function automatic logic [63:0] sxw(logic [31:0] x);
    return {{32{x[31]}}, x};
  endfunction

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1, 4'd2: return "R5";
      4'd3: return "R4";
      4'd4, 4'd5: return "R6";
      4'd6: return "R7";
      4'd8: return "R9";
      default: return "R8";
    endcase
  endfunction

  // Reference model: 128-bit modular products of widened operands.
  task automatic model(input logic [3:0] o, input logic [63:0] a, b, c, input logic [15:0] im,
                       output logic [63:0] r, output logic of);
    logic [127:0] p;
    logic [63:0]  w;
    of = 1'b0;
    case (o)
      4'd0: begin p = sx(a) * sx(b); r = p[63:0];
                  of = !((p[127:63] == '0) || (p[127:63] == {65{1'b1}})); end
      4'd1: begin p = sx(a) * sx(b); r = p[127:64]; end
      4'd2: begin p = {64'd0, a} * {64'd0, b}; r = p[127:64]; end
      4'd3: begin w = sxw(a[31:0]) * sxw(b[31:0]); r = w;
                  of = !((w[63:31] == '0) || (w[63:31] == {33{1'b1}})); end
      4'd4: begin w = sxw(a[31:0]) * sxw(b[31:0]); r = {w[63:32], w[63:32]}; end
      4'd5: begin w = {32'd0, a[31:0]} * {32'd0, b[31:0]}; r = {w[63:32], w[63:32]}; end
      4'd6: begin p = sx(a) * sx({{48{im[15]}}, im}); r = p[63:0]; end
      4'd7: begin p = sx(a) * sx(b) + sx(c); r = p[127:64]; end
      4'd8: begin p = {64'd0, a} * {64'd0, b} + {64'd0, c}; r = p[127:64]; end
      default: begin p = sx(a) * sx(b) + sx(c); r = p[63:0]; end
    endcase
  endtask

  task automatic run_op(input logic [3:0] o, input logic [63:0] a, b, c, input logic [15:0] im,
                        input logic e, input logic rc, input logic so, input bit intrude);
    logic [63:0] er;
    logic        eof, ewr, eov, ecw;
    logic [3:0]  ecr;
    int k;
    bit got;
    model(o, a, b, c, im, er, eof);
    ewr = e && (o == 4'd0 || o == 4'd3);
    eov = ewr && eof;
    ecw = rc && (o <= 4'd5);
    ecr = {er[63], !er[63] && (er != 0), er == 0, so | eov};
    @(negedge clk);
    op = o; src_a = a; src_b = b; src_c = c; imm = im; oe = e; rec = rc; so_in = so;
    start = 1'b1;
    k = 0; got = 0;
    while (!got && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start = 1'b0;
        check("R1 busy after accept", {63'd0, busy}, 64'd1);
      end
      if (intrude && k == 4) begin
        start = 1'b1; op = 4'd2; src_a = ~a; src_b = ~b; src_c = ~c; imm = ~im;
      end
      if (intrude && k == 5) start = 1'b0;
      if (done) got = 1;
    end
    check("R1 done latency", 64'(k), 64'(LAT));
    check(tag_of(o), result, er);
    check("R10 ov_wr", {63'd0, ov_wr}, {63'd0, ewr});
    check("R10 ov", {63'd0, ov}, {63'd0, eov});
    check("R11 cr0_wr", {63'd0, cr0_wr}, {63'd0, ecw});
    if (ecw) check("R11 cr0", {60'd0, cr0}, {60'd0, ecr});
    @(negedge clk);
    check("R1 done one cycle", {63'd0, done}, 64'd0);
    if (intrude) begin
      got = 0;
      for (int i = 0; i < LAT + 8; i++) begin
        @(negedge clk);
        if (done) got = 1;
      end
      check("R2 no extra done", {63'd0, got}, 64'd0);
      check("R2 result kept", result, er);
    end
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 7))
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_8000_0000;
      6: return 64'hFFFF_FFFF_7FFF_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", {63'd0, busy}, 64'd0);
    check("R12 done", {63'd0, done}, 64'd0);
    check("R12 result", result, 64'd0);
    check("R12 flags", {59'd0, ov_wr, ov, cr0_wr, cr0[1:0]}, 64'd0);
    check("R12 cr0", {60'd0, cr0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_op(4'd0, 64'h8000_0000_0000_0000, '1, 0, 0, 1, 1, 0, 0);             // R3 overflow
    run_op(4'd0, '1, '1, 0, 0, 1, 1, 0, 0);                                  // R3 no overflow
    run_op(4'd3, 64'h1234_5678_8000_0000, 64'h0_8000_0000, 0, 0, 1, 1, 0, 0); // R4 overflow
    run_op(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 0, 0, 1, 1, 1, 0);          // R4 small, so_in
    run_op(4'd2, '1, '1, 0, 0, 0, 1, 0, 0);                                  // R5
    run_op(4'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 1, 1, 0, 0);
    run_op(4'd4, 64'h0_8000_0000, 64'h0_7FFF_FFFF, 0, 0, 1, 1, 0, 0);        // R6 signed
    run_op(4'd5, '1, '1, 0, 0, 1, 1, 0, 0);                                  // R6 unsigned
    run_op(4'd6, 64'h0000_0000_0001_0000, 0, 0, 16'h8000, 1, 1, 0, 0);       // R7
    run_op(4'd7, '1, 64'd5, 64'h8000_0000_0000_0000, 0, 1, 1, 0, 0);         // R8 high
    run_op(4'd9, 64'd3, 64'd4, '1, 0, 1, 1, 0, 0);                           // R8 low
    run_op(4'd8, '1, '1, '1, 0, 1, 1, 0, 0);                                 // R9
    run_op(4'd0, 64'd0, 64'd12345, 0, 0, 1, 1, 0, 1);                        // R2 intrusion

    // Random mix
    for (int n = 0; n < 300; n++) begin
      run_op(4'($urandom_range(0, 9)), pick(), pick(), pick(), 16'($urandom()),
             1'($urandom()), 1'($urandom()), 1'($urandom()), (n % 50) == 7);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule